// File: doc/BRIEF.md
# Display Output Latch and Busy Controller

This block decides, on every rising edge of the interface strobe, whether the display RAM should be copied into the output latch that feeds the segment and common sequencer. The decision comes from two configuration flags: a "copy after data" mode bit and a "copy on every strobe" bit. While a copy is in progress, the block drives an active-low busy output for a fixed window. The window is counted in oscillator half-periods, and its default of 1009 half-periods equals 504.5 oscillator periods.

The output latch has two banks. The copy engine reads the display RAM in ascending address order, one byte per clock, and writes the inactive bank. The sequencer keeps reading the active bank. When the busy window closes, the banks swap in a single cycle, so the sequencer never shows a half-copied frame.

A strobe edge of either polarity that arrives while busy is low aborts the copy. It then asks the serial receiver to restart and asks for the display-on flag to be cleared. After reset the block sleeps with busy low until the first strobe edge of either polarity. That edge wakes it and sends the receiver into command-wait.

Top module: `disp_latch_ctl`

## Requirements
- R1: After reset `busy_n` is 0 and stays 0 until the first strobe edge of either polarity. The clock edge that takes that strobe pulse drives `busy_n` to 1 and `ser_reset` to 1 for one cycle. The wake edge never starts a copy.
- R2: With `latch_mode`=0 and `latch_flag`=0, a strobe rise leaves `busy_n` at 1 and never changes the latch contents, whatever the value of `data_rx`.
- R3: With `latch_flag`=1, every strobe rise taken while idle starts a copy, whatever `latch_mode` and `data_rx` are. `busy_n` goes to 0 on the next clock edge.
- R4: With `latch_mode`=1 and `latch_flag`=0, a strobe rise starts a copy only if `data_rx` is 1 in the same cycle.
- R5: From a copy start, `busy_n` stays 0 for exactly `HALF_TICKS` cycles in which `osc_tick` is 1 and the block is busy. It returns to 1 on the clock edge that takes the last of those ticks.
- R6: `ram_rd_en` rises together with the falling edge of `busy_n`. The block then asserts it for exactly `DEPTH` consecutive cycles, with `ram_rd_addr` running 0, 1, …, `DEPTH`-1. RAM read data is expected one clock after the address.
- R7: During a copy the sequencer port returns the contents of the previous copy. `latch_en` pulses for one cycle in the cycle in which `busy_n` returns to 1. From then on, the sequencer port returns the newly copied bytes.
- R8: A strobe edge of either polarity while a copy is running sets `busy_n` to 1 on the next clock edge. `ser_reset` and `clr_dispon` then pulse for one cycle, `latch_en` does not pulse, and the sequencer keeps the previous contents.
- R9: A strobe fall while idle, and a strobe rise that starts no copy, produce no `ser_reset` pulse and no `clr_dispon` pulse.
- R10: The sequencer read port has one clock of latency. `seq_rd_data` shows the byte at the `seq_rd_addr` presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| stb_rise | input | 1 | One-cycle pulse: strobe rising edge detected |
| stb_fall | input | 1 | One-cycle pulse: strobe falling edge detected |
| data_rx | input | 1 | Display data was received in the frame this rise closes |
| latch_mode | input | 1 | Copy after a data frame |
| latch_flag | input | 1 | Copy on every strobe rise |
| osc_tick | input | 1 | One pulse per oscillator half-period |
| ram_rd_en | output | 1 | Display RAM read enable |
| ram_rd_addr | output | AW | Display RAM byte address |
| ram_rd_data | input | DW | Display RAM read data, one cycle after address |
| seq_rd_addr | input | AW | Sequencer byte address into the active latch bank |
| seq_rd_data | output | DW | Latched byte, one cycle after address |
| latch_en | output | 1 | One-cycle pulse when the new contents take effect |
| busy_n | output | 1 | Active-low busy |
| clr_dispon | output | 1 | One-cycle request to clear the display-on flag |
| ser_reset | output | 1 | One-cycle request to restart the serial receiver |

## Verification
The checks take for granted that `stb_rise` and `stb_fall` are never high in the same cycle, and that `osc_tick` is a single-cycle pulse. They also assume that the busy window lasts more clocks than the `DEPTH`+1 cycles a copy needs. A bank swap can therefore never catch a write still in flight. The stimulus toggles `osc_tick` every other clock, so the window lasts about 2018 clocks against a 31-cycle copy. It raises strobe pulses one at a time, each for one cycle, with the flags already held steady.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;

  typedef enum logic [1:0] {
    ST_WAKE = 2'd0,
    ST_IDLE = 2'd1,
    ST_BUSY = 2'd2
  } lctl_state_e;

  // copy decision for a strobe rise
  function automatic logic copy_wanted(input logic after_data,
                                       input logic every_rise,
                                       input logic had_data);
    return every_rise | (after_data & had_data);
  endfunction

endpackage

// File: rtl/lcdl_window_timer.sv
module lcdl_window_timer #(
  parameter int HALF_TICKS = 1009
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(HALF_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign done = run & tick & (cnt_q == LAST);
endmodule

// File: rtl/lcdl_copy_engine.sv
module lcdl_copy_engine #(
  parameter int DEPTH = 30,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          abort,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          run_q;
  logic [AW-1:0] addr_q;
  logic          wr_en_q;
  logic [AW-1:0] wr_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      addr_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
    end else begin
      wr_en_q   <= run_q & ~abort;
      wr_addr_q <= addr_q;
      if (abort) begin
        run_q <= 1'b0;
      end else if (go) begin
        run_q  <= 1'b1;
        addr_q <= '0;
      end else if (run_q) begin
        if (addr_q == LAST) run_q  <= 1'b0;
        else                addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign rd_en   = run_q;
  assign rd_addr = addr_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
endmodule

// File: rtl/lcdl_shadow.sv
module lcdl_shadow #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int SLOTS = 2 ** (AW + 1);

  logic [DW-1:0] mem [SLOTS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
    rdata_q <= mem[{rbank, raddr}];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/disp_latch_ctl.sv
module disp_latch_ctl
  import lcdl_pkg::*;
#(
  parameter int DEPTH      = 30,
  parameter int DW         = 8,
  parameter int HALF_TICKS = 1009,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_rise,
  input  logic          stb_fall,
  input  logic          data_rx,
  input  logic          latch_mode,
  input  logic          latch_flag,
  input  logic          osc_tick,
  output logic          ram_rd_en,
  output logic [AW-1:0] ram_rd_addr,
  input  logic [DW-1:0] ram_rd_data,
  input  logic [AW-1:0] seq_rd_addr,
  output logic [DW-1:0] seq_rd_data,
  output logic          latch_en,
  output logic          busy_n,
  output logic          clr_dispon,
  output logic          ser_reset
);
  lctl_state_e   state_q;
  logic          busy_n_q, latch_en_q, clr_q, ser_reset_q, bank_q;
  logic          any_edge, wake, go, abort, win_done;
  logic          cp_wr_en;
  logic [AW-1:0] cp_wr_addr;

  assign any_edge = stb_rise | stb_fall;
  assign wake  = (state_q == ST_WAKE) & any_edge;
  assign go    = (state_q == ST_IDLE) & stb_rise &
                 copy_wanted(latch_mode, latch_flag, data_rx);
  assign abort = (state_q == ST_BUSY) & any_edge;

  lcdl_window_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (state_q == ST_BUSY),
    .tick(osc_tick),
    .done(win_done)
  );

  lcdl_copy_engine #(.DEPTH(DEPTH), .AW(AW)) u_copy (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .abort  (abort),
    .rd_en  (ram_rd_en),
    .rd_addr(ram_rd_addr),
    .wr_en  (cp_wr_en),
    .wr_addr(cp_wr_addr)
  );

  lcdl_shadow #(.DW(DW), .AW(AW)) u_shadow (
    .clk  (clk),
    .we   (cp_wr_en),
    .wbank(~bank_q),
    .waddr(cp_wr_addr),
    .wdata(ram_rd_data),
    .rbank(bank_q),
    .raddr(seq_rd_addr),
    .rdata(seq_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_WAKE;
      busy_n_q    <= 1'b0;
      latch_en_q  <= 1'b0;
      clr_q       <= 1'b0;
      ser_reset_q <= 1'b0;
      bank_q      <= 1'b0;
    end else begin
      latch_en_q  <= 1'b0;
      clr_q       <= 1'b0;
      ser_reset_q <= 1'b0;
      case (state_q)
        ST_WAKE: if (wake) begin
          state_q     <= ST_IDLE;
          busy_n_q    <= 1'b1;
          ser_reset_q <= 1'b1;
        end
        ST_IDLE: if (go) begin
          state_q  <= ST_BUSY;
          busy_n_q <= 1'b0;
        end
        ST_BUSY: begin
          if (abort) begin
            state_q     <= ST_IDLE;
            busy_n_q    <= 1'b1;
            ser_reset_q <= 1'b1;
            clr_q       <= 1'b1;
          end else if (win_done) begin
            state_q    <= ST_IDLE;
            busy_n_q   <= 1'b1;
            latch_en_q <= 1'b1;
            bank_q     <= ~bank_q;
          end
        end
        default: begin
          state_q  <= ST_WAKE;
          busy_n_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy_n     = busy_n_q;
  assign latch_en   = latch_en_q;
  assign clr_dispon = clr_q;
  assign ser_reset  = ser_reset_q;
endmodule

// File: rtl/lcdl_checker.sv
module lcdl_checker #(
  parameter int HALF_TICKS = 1009
) (
  input logic clk,
  input logic rst,
  input logic stb_rise,
  input logic stb_fall,
  input logic data_rx,
  input logic latch_mode,
  input logic latch_flag,
  input logic osc_tick,
  input logic ram_rd_en,
  input logic cp_wr_en,
  input logic latch_en,
  input logic busy_n,
  input logic clr_dispon,
  input logic ser_reset
);
  localparam int CW = $clog2(HALF_TICKS + 2);

  logic          woke_q;
  logic [CW-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) woke_q <= 1'b0;
    else if (stb_rise || stb_fall) woke_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || busy_n) win_q <= '0;
    else if (woke_q && osc_tick) win_q <= win_q + 1'b1;
  end

  assert_asleep_busy_low_R1: assert property (@(posedge clk) disable iff (rst)
    !woke_q |-> !busy_n) else $error("R1 busy high before wake");

  assert_wake_edge_R1: assert property (@(posedge clk) disable iff (rst)
    (!woke_q && (stb_rise || stb_fall)) |=> (busy_n && ser_reset && !clr_dispon && !latch_en))
    else $error("R1 wake response");

  assert_mode_off_R2: assert property (@(posedge clk) disable iff (rst)
    (woke_q && busy_n && stb_rise && !latch_flag && !latch_mode) |=> busy_n)
    else $error("R2 copy started with both flags clear");

  assert_every_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (woke_q && busy_n && stb_rise && latch_flag) |=> !busy_n)
    else $error("R3 copy not started");

  assert_data_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (woke_q && busy_n && stb_rise && !latch_flag && latch_mode) |=> (busy_n != $past(data_rx)))
    else $error("R4 data gating");

  assert_window_len_R5: assert property (@(posedge clk) disable iff (rst)
    latch_en |-> (win_q == CW'(HALF_TICKS))) else $error("R5 window length");

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (woke_q && !busy_n) |-> (win_q < CW'(HALF_TICKS))) else $error("R5 window overrun");

  assert_read_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> !busy_n) else $error("R6 read outside busy");

  assert_commit_on_release_R7: assert property (@(posedge clk) disable iff (rst)
    latch_en |-> (busy_n && $past(!busy_n) && !ram_rd_en && !cp_wr_en))
    else $error("R7 commit timing");

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (woke_q && !busy_n && (stb_rise || stb_fall)) |=> (busy_n && ser_reset && clr_dispon && !latch_en))
    else $error("R8 abort response");

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (woke_q && busy_n && !stb_rise) |=> (!ser_reset && !clr_dispon))
    else $error("R9 spurious request");
endmodule

bind disp_latch_ctl lcdl_checker #(.HALF_TICKS(HALF_TICKS)) u_lcdl_chk (
  .clk       (clk),
  .rst       (rst),
  .stb_rise  (stb_rise),
  .stb_fall  (stb_fall),
  .data_rx   (data_rx),
  .latch_mode(latch_mode),
  .latch_flag(latch_flag),
  .osc_tick  (osc_tick),
  .ram_rd_en (ram_rd_en),
  .cp_wr_en  (cp_wr_en),
  .latch_en  (latch_en),
  .busy_n    (busy_n),
  .clr_dispon(clr_dispon),
  .ser_reset (ser_reset)
);

// File: tb/tb_disp_latch_ctl.sv
`timescale 1ns/1ps
module tb_disp_latch_ctl;
  localparam int DEPTH = 30;
  localparam int DW    = 8;
  localparam int HT    = 1009;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic stb_rise = 0, stb_fall = 0, data_rx = 0, latch_mode = 0, latch_flag = 0;
  logic osc_tick = 0;
  logic ram_rd_en;
  logic [AW-1:0] ram_rd_addr;
  logic [DW-1:0] ram_rd_data = '0;
  logic [AW-1:0] seq_rd_addr = '0;
  logic [DW-1:0] seq_rd_data;
  logic latch_en, busy_n, clr_dispon, ser_reset;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] src   [DEPTH];
  logic [DW-1:0] shown [DEPTH];

  int win_t = 0, rd_i = 0, rd_b = 0, t_now = 0;
  int last_t = 0, last_rd = 0, last_bad = 0, latch_cnt = 0;
  logic was_low = 0;

  always #2.5 clk = ~clk;

  disp_latch_ctl #(.DEPTH(DEPTH), .DW(DW), .HALF_TICKS(HT)) dut (
    .clk(clk), .rst(rst), .stb_rise(stb_rise), .stb_fall(stb_fall),
    .data_rx(data_rx), .latch_mode(latch_mode), .latch_flag(latch_flag),
    .osc_tick(osc_tick), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
    .ram_rd_data(ram_rd_data), .seq_rd_addr(seq_rd_addr), .seq_rd_data(seq_rd_data),
    .latch_en(latch_en), .busy_n(busy_n), .clr_dispon(clr_dispon), .ser_reset(ser_reset)
  );

  // display RAM model, one clock read latency
  always @(posedge clk) if (ram_rd_en) ram_rd_data <= src[ram_rd_addr];

  // oscillator ticks and window monitor
  always @(negedge clk) begin
    osc_tick <= ~osc_tick;
    if (rst) begin
      win_t <= 0; rd_i <= 0; rd_b <= 0; was_low <= 0;
    end else begin
      t_now = win_t + ((was_low && osc_tick) ? 1 : 0);
      if (busy_n && was_low) begin
        last_t <= t_now; last_rd <= rd_i; last_bad <= rd_b;
        win_t <= 0; rd_i <= 0; rd_b <= 0;
      end else begin
        win_t <= t_now;
        if (ram_rd_en) begin
          rd_i <= rd_i + 1;
          if (int'(ram_rd_addr) != rd_i) rd_b <= rd_b + 1;
        end
      end
      was_low <= !busy_n;
      if (latch_en) latch_cnt <= latch_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit rise);
    @(negedge clk);
    if (rise) stb_rise = 1; else stb_fall = 1;
    @(negedge clk);
    stb_rise = 0; stb_fall = 0;
  endtask

  task automatic set_flags(input bit m, input bit f, input bit d);
    latch_mode = m; latch_flag = f; data_rx = d;
  endtask

  task automatic fill_src(input int seed);
    for (int i = 0; i < DEPTH; i++) src[i] = 8'((i * seed + seed * 13) ^ (seed << 2));
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_n !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic read_seq(input int a, output logic [DW-1:0] d);
    @(negedge clk); seq_rd_addr = AW'(a);
    @(negedge clk); d = seq_rd_data;
  endtask

  task automatic check_shown(input string req);
    logic [DW-1:0] d;
    int bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      read_seq(i, d);
      if (d !== shown[i]) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic t_power_up();
    chk("R1 busy low after reset", busy_n, 0);
    chk("R1 no serial reset in reset", ser_reset, 0);
    repeat (6) @(negedge clk);
    chk("R1 busy held low before strobe", busy_n, 0);
    set_flags(0, 1, 1);
    strobe(1);
    chk("R1 busy high after wake", busy_n, 1);
    chk("R1 serial reset on wake", ser_reset, 1);
    chk("R1 no clear on wake", clr_dispon, 0);
    @(negedge clk);
    chk("R1 serial reset one cycle", ser_reset, 0);
    chk("R1 wake starts no copy", busy_n, 1);
  endtask

  task automatic t_data_mode();
    int lat;
    set_flags(1, 0, 0);
    strobe(1);
    chk("R4 no copy without data", busy_n, 1);
    chk("R9 no serial reset on plain rise", ser_reset, 0);
    fill_src(3);
    lat = latch_cnt;
    set_flags(1, 0, 1);
    strobe(1);
    chk("R4 copy after data", busy_n, 0);
    chk("R6 read enable with busy fall", ram_rd_en, 1);
    chk("R6 first address zero", ram_rd_addr, 0);
    wait_idle();
    chk("R5 window half ticks", last_t, HT);
    chk("R6 bytes read", last_rd, DEPTH);
    chk("R6 ascending order", last_bad, 0);
    chk("R7 one latch pulse", latch_cnt, lat + 1);
    for (int i = 0; i < DEPTH; i++) shown[i] = src[i];
    check_shown("R7 new contents shown");
  endtask

  task automatic t_flag_every();
    logic [DW-1:0] d;
    fill_src(5);
    set_flags(0, 1, 0);
    strobe(1);
    chk("R3 command-only rise copies", busy_n, 0);
    repeat (200) @(negedge clk);
    read_seq(0, d);
    chk("R7 old byte 0 during copy", d, shown[0]);
    read_seq(DEPTH - 1, d);
    chk("R10 old last byte during copy", d, shown[DEPTH-1]);
    wait_idle();
    chk("R5 window half ticks again", last_t, HT);
    for (int i = 0; i < DEPTH; i++) shown[i] = src[i];
    check_shown("R7 contents after flag copy");
    fill_src(7);
    set_flags(1, 1, 0);
    strobe(1);
    chk("R3 rise copies with both flags", busy_n, 0);
    wait_idle();
    for (int i = 0; i < DEPTH; i++) shown[i] = src[i];
    check_shown("R3 contents after second copy");
  endtask

  task automatic t_mode_off();
    int lat;
    fill_src(9);
    lat = latch_cnt;
    set_flags(0, 0, 1);
    strobe(1);
    chk("R2 no busy with flags clear", busy_n, 1);
    repeat (20) @(negedge clk);
    chk("R2 still idle", busy_n, 1);
    chk("R2 no latch pulse", latch_cnt, lat);
    check_shown("R2 contents unchanged");
  endtask

  task automatic t_abort();
    int lat;
    fill_src(11);
    lat = latch_cnt;
    set_flags(0, 1, 0);
    strobe(1);
    chk("R8 copy running", busy_n, 0);
    repeat (300) @(negedge clk);
    strobe(0);
    chk("R8 busy released by fall", busy_n, 1);
    chk("R8 serial reset", ser_reset, 1);
    chk("R8 display clear", clr_dispon, 1);
    chk("R8 no latch pulse", latch_en, 0);
    @(negedge clk);
    chk("R8 clear one cycle", clr_dispon, 0);
    check_shown("R8 old contents kept");
    strobe(1);
    repeat (300) @(negedge clk);
    strobe(1);
    chk("R8 busy released by rise", busy_n, 1);
    chk("R8 display clear on rise", clr_dispon, 1);
    @(negedge clk);
    chk("R8 no restart after abort", busy_n, 1);
    chk("R8 no latch after aborts", latch_cnt, lat);
    check_shown("R8 contents after second abort");
  endtask

  task automatic t_idle_edges();
    set_flags(0, 0, 0);
    strobe(0);
    chk("R9 fall idle no serial reset", ser_reset, 0);
    chk("R9 fall idle no clear", clr_dispon, 0);
    chk("R9 fall idle busy high", busy_n, 1);
    strobe(1);
    chk("R9 rise idle no clear", clr_dispon, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_power_up();
    t_data_mode();
    t_flag_every();
    t_mode_off();
    t_abort();
    t_idle_edges();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule